// File: doc/BRIEF.md
# CPU Sleep and Throttle Manager

This block decides, cycle by cycle, whether the processor core may advance, by driving its clock-enable input. Software reaches it through two byte-wide registers on a simple write-strobe bus with a combinational read port. The control register can put the core to sleep until one of its selected interrupt lines is raised. It can also place the core in a slowed mode. The power register sets how strongly the slowed mode throttles the core.

Throttling uses an 8-bit counter that runs freely and is compared with the power value. The enable is high while the counter is at or below that value, so in every 256-cycle period the core gets power+1 enabled cycles. Sleep is held by a three-state machine with the states RUN, SLOW and HALT. A write to the control register moves it to HALT when bit 0 is set, otherwise to SLOW when bit 1 is set, otherwise to RUN. While in HALT with no control write, a watched interrupt line moves it back to SLOW when the slow bit is set, or to RUN when it is not. Leaving HALT this way clears only the sleep bit. A control write issued in the same cycle as a wake takes precedence over the wake.

Top module: `cpu_pace_ctrl`

## Requirements
- R1: After the active-low reset both registers read 0 and `cpu_en` is constantly high.
- R2: The control register (address 0) reads back bit 0 as sleep, bit 1 as slow and bits 7:4 as the watch mask as written; bits 3:2 always read 0.
- R3: The power register (address 1) reads back all 8 bits as written.
- R4: Writing control bit 0 as 1 drives `cpu_en` low from the cycle after the write, and it stays low until a wake or a new control write.
- R5: A raised interrupt line whose mask bit (bit 4+i for line i) is 0 has no effect: the core stays asleep and control bit 0 still reads 1.
- R6: A watched interrupt line raised while asleep clears control bit 0 on the next clock edge and leaves the slow bit and the mask unchanged.
- R7: With slow set and sleep clear, `cpu_en` is high for exactly power+1 cycles in every run of 256 consecutive cycles.
- R8: With slow set and power 255, `cpu_en` is high in every cycle.
- R9: When sleep and slow are both set, sleep wins and `cpu_en` is low.
- R10: Both registers accept writes while the core is asleep; writing control 0 then releases the core at once.
- R11: With sleep and slow both clear, `cpu_en` is high in every cycle whatever the power value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 power |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | input | 4 | Interrupt lines 0 to 3, active high |
| cpu_en | output | 1 | Clock enable for the processor core |

## Verification
The duty cycle is swept over all 256 power values in slow mode. Counting the high cycles in a full 256-cycle window separates an off-by-one comparison, or an inverted one, from the correct power+1 result, and the value 255 separates an `<=` compare from a `<` compare. Sleep is tried with every one of the 16 watch masks against each single interrupt line, with the slow bit both clear and set. This separates lines that are watched from lines that are not, and it checks that a wake keeps the slow bit and the mask. Writes made while the core is asleep and a steady RUN window with a nonzero power value complete the picture.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SLOW = 2'd1,
        ST_HALT = 2'd2
    } pace_st_e;

    localparam int SLEEP_BIT = 0;
    localparam int SLOW_BIT  = 1;
    localparam int CTRL_OFS  = 0;
    localparam int POWER_OFS = 1;
endpackage

// File: rtl/cpa_pwm.sv
module cpa_pwm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_i,
    output logic             on_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign on_o = (cnt_q <= duty_i);

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/cpa_regs.sv
module cpa_regs
    import cpa_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IRQ_N  = 4,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              asleep_i,
    output logic              ctrl_wr_o,
    output logic [DATA_W-1:0] power_o,
    output logic [IRQ_N-1:0]  mask_o,
    output logic              slow_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int MASK_LSB = DATA_W - IRQ_N;
    localparam int PAD_W    = MASK_LSB - 2;

    logic power_wr;
    logic [DATA_W-1:0] ctrl_view;

    assign ctrl_wr_o = wr_i && (addr_i == ADDR_W'(CTRL_OFS));
    assign power_wr  = wr_i && (addr_i == ADDR_W'(POWER_OFS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            power_o <= '0;
            mask_o  <= '0;
            slow_o  <= 1'b0;
        end else begin
            if (power_wr) power_o <= wdata_i;
            if (ctrl_wr_o) begin
                mask_o <= wdata_i[DATA_W-1:MASK_LSB];
                slow_o <= wdata_i[SLOW_BIT];
            end
        end
    end

    assign ctrl_view = {mask_o, {PAD_W{1'b0}}, slow_o, asleep_i};

    always_comb begin
        unique case (addr_i)
            ADDR_W'(CTRL_OFS):  rdata_o = ctrl_view;
            ADDR_W'(POWER_OFS): rdata_o = power_o;
            default:            rdata_o = '0;
        endcase
    end

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(CTRL_OFS)) |-> rdata_o[MASK_LSB-1:2] == '0);

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_o |=> $stable(mask_o) && $stable(slow_o));
endmodule

// File: rtl/cpa_fsm.sv
module cpa_fsm
    import cpa_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IRQ_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IRQ_N-1:0]  irq_i,
    input  logic [IRQ_N-1:0]  mask_i,
    input  logic              slow_i,
    input  logic              pwm_on_i,
    output logic              asleep_o,
    output logic              en_o
);
    pace_st_e st_q, st_d;
    logic     wake;

    assign wake = |(irq_i & mask_i);

    always_comb begin
        st_d = st_q;
        if (ctrl_wr_i) begin
            if (wdata_i[SLEEP_BIT])     st_d = ST_HALT;
            else if (wdata_i[SLOW_BIT]) st_d = ST_SLOW;
            else                        st_d = ST_RUN;
        end else if (st_q == ST_HALT && wake) begin
            st_d = slow_i ? ST_SLOW : ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_RUN:  en_o = 1'b1;
            ST_SLOW: en_o = pwm_on_i;
            ST_HALT: en_o = 1'b0;
            default: en_o = 1'b0;
        endcase
    end

    assign asleep_o = (st_q == ST_HALT);

    // R4
    halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |-> !en_o);

    // R6
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !ctrl_wr_i && wake) |=> st_q != ST_HALT);

    // R5
    stay_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !ctrl_wr_i && !wake) |=> st_q == ST_HALT);

    // R11
    run_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> en_o);
endmodule

// File: rtl/cpu_pace_ctrl.sv
module cpu_pace_ctrl #(
    parameter int DATA_W = 8,
    parameter int IRQ_N  = 4,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IRQ_N-1:0]  irq,
    output logic              cpu_en
);
    logic              ctrl_wr;
    logic [DATA_W-1:0] power;
    logic [IRQ_N-1:0]  mask;
    logic              slow;
    logic              asleep;
    logic              pwm_on;

    cpa_regs #(.DATA_W(DATA_W), .IRQ_N(IRQ_N), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .asleep_i(asleep), .ctrl_wr_o(ctrl_wr),
        .power_o(power), .mask_o(mask), .slow_o(slow), .rdata_o(bus_rdata)
    );

    cpa_pwm #(.CNT_W(DATA_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .duty_i(power), .on_o(pwm_on)
    );

    cpa_fsm #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .wdata_i(bus_wdata),
        .irq_i(irq), .mask_i(mask), .slow_i(slow), .pwm_on_i(pwm_on),
        .asleep_o(asleep), .en_o(cpu_en)
    );

    // R8
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow && !asleep && power == '1) |-> cpu_en);

    // R9
    sleep_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && slow) |-> !cpu_en);
endmodule

// File: tb/cpu_pace_ctrl_tb.sv
module cpu_pace_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [0:0] bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] irq = 4'h0;
    logic       cpu_en;

    int checks = 0;
    int errors = 0;

    cpu_pace_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cpu_en(cpu_en)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic count_high(output int n);
        n = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (cpu_en) n++;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(1'b0, v); check("R1 ctrl", v, 0);
        rd(1'b1, v); check("R1 power", v, 0);
        count_high(n); check("R1 en", n, 256);

        // R7 / R3 / R8 duty sweep in slow mode
        wr(1'b0, 8'h02);
        for (int p = 0; p < 256; p++) begin
            wr(1'b1, 8'(p));
            rd(1'b1, v); check("R3 power", v, p);
            count_high(n); check(p == 255 ? "R8 full" : "R7 duty", n, p + 1);
        end

        // R11 neither mode: constant high with nonzero power
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h00);
        count_high(n); check("R11 run", n, 256);

        // R2 readback, unused bits 3:2
        wr(1'b0, 8'hFE); rd(1'b0, v); check("R2 ctrl", v, 8'hF2);
        wr(1'b0, 8'h0C); rd(1'b0, v); check("R2 pad", v, 8'h00);

        // sleep sweep: all masks x each line x slow bit
        wr(1'b1, 8'hFF);
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 16; m++) begin
                for (int i = 0; i < 4; i++) begin
                    logic [7:0] cv;
                    cv = 8'((m << 4) | (s << 1) | 1);
                    wr(1'b0, cv);
                    n = 0;
                    for (int k = 0; k < 3; k++) begin
                        @(negedge clk); if (cpu_en) n++;
                    end
                    check(s == 1 ? "R9 sleep over slow" : "R4 sleep", n, 0);
                    irq = 4'(1 << i);
                    @(negedge clk);
                    irq = 4'h0;
                    rd(1'b0, v);
                    if (m[i]) begin
                        check("R6 wake ctrl", v, cv & 8'hFE);
                        check("R6 wake en", cpu_en, 1);
                    end else begin
                        check("R5 ignored ctrl", v, cv);
                        check("R5 ignored en", cpu_en, 0);
                    end
                    wr(1'b0, 8'h00);
                end
            end
        end

        // R10 writes while asleep
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h5A);
        rd(1'b1, v); check("R10 power write", v, 8'h5A);
        check("R10 still asleep", cpu_en, 0);
        wr(1'b0, 8'h00);
        rd(1'b0, v); check("R10 release ctrl", v, 0);
        check("R10 release en", cpu_en, 1);

        // R6 with slow and partial duty: wake resumes throttling
        wr(1'b0, 8'h23);
        irq = 4'h2;
        @(negedge clk);
        irq = 4'h0;
        rd(1'b0, v); check("R6 keep slow", v, 8'h22);
        count_high(n); check("R6 throttled", n, 8'h5A + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule